// File: doc/BRIEF.md
# MDIO Management Frame Master

The block runs one serial management transaction at a time on a two-wire PHY management bus (MDC clock, bidirectional MDIO data). The host writes a single 32-bit command word that already holds the complete frame: start code, opcode, a 5-bit PHY address, a 5-bit register address, turnaround code and, for a write, 16 bits of data. The block sends a run of ones as a preamble and then shifts the word out MSB first. For a read, it releases the line after the address fields and samples the 16 data bits that the PHY returns.

When the last bit has gone by, the block writes the reply back into the command register and sets a sticky completion flag. The host polls that flag and clears it by writing a 1. The MDC period comes from a host-loaded speed field that divides the system clock. A self-clearing soft-reset control aborts any transaction in flight and reads back as 1 until the internal reset sequence has finished.

Top module: `mdio_master`

## Requirements
- R1: A transaction starts with PRE_LEN (32) MDC periods of MDIO=1. The 32-bit command word then follows, MSB first, one bit per MDC period. A read word has the form 0x60020000 | PHY<<23 | REG<<18, where bits 29:28 = 2'b10 mark a read. A write word has the form 0x50020000 | PHY<<23 | REG<<18 | DATA.
- R2: In a read, the block drives MDIO (mdio_oe=1) only for the preamble and the first 14 frame bits, and releases it for the remaining 18. On the MDC rising edges of the last 16 bits it samples mdio_i, MSB first, into reply bits 15:0. Reply bits 31:16 keep the command's bits.
- R3: In a write (any opcode other than 2'b10), all 64 bits are driven, and the reply equals the command word.
- R4: A read with no PHY driving the line, so that mdio_i stays high, returns 0xFFFF in reply bits 15:0.
- R5: The speed field F is the host speed value's bits 6:1, presented on spd_wdata. Each MDC phase lasts F system clocks, and F=0 counts as 1. While idle, MDC is low and MDIO is released.
- R6: MDIO output and enable change only on MDC falling edges. They are stable when MDC rises.
- R7: busy rises in the cycle after an accepted command write and stays high for exactly 128*F cycles. The reply and the completion flag appear in the same cycle that busy falls.
- R8: The completion flag is set at the end of every transaction and stays set until an evt_we write with evt_wbit=1. A write with evt_wbit=0 leaves it set.
- R9: A command write while busy is ignored. The running transaction and its reply are unaffected.
- R10: A pulse on srst_req makes srst_busy read 1 for RST_CYCLES (8) cycles, after which it clears itself. During that time, any transaction is aborted (MDC low, MDIO released), the completion flag is cleared, and command writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe; starts a transaction |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Command/reply register contents |
| spd_we | input | 1 | Speed field write strobe |
| spd_wdata | input | DIV_W | Speed field F (host word bits 6:1) |
| evt_we | input | 1 | Completion flag write strobe |
| evt_wbit | input | 1 | Write-1-to-clear value for the completion flag |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | Transaction in progress |
| srst_req | input | 1 | Soft-reset request |
| srst_busy | output | 1 | Soft reset in progress; clears itself |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
busy is due one clock after the write strobe. It then holds for exactly 128*F clocks, and the reply and done change on the same edge where busy falls. The bench samples at falling clock edges and counts the high samples of busy and MDC, so it checks the exact duration rather than polling with slack. The serial line is captured on every MDC rise and compared bit by bit with the expected 64-bit pattern and drive mask. A PHY model updates mdio_i after each MDC fall, a full phase ahead of the sampling edge. Soft-reset length is checked by counting srst_busy samples.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W    = 32;
    localparam int DATA_W   = 16;
    localparam int HDR_BITS = 14;   // start + opcode + PHY + register
    localparam int TA_BITS  = 2;
    localparam logic [1:0] OP_READ = 2'b10;

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return c[29:28] == OP_READ;
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cyc,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t             st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (half_cyc == '0) ? DIV_W'(1) : half_cyc;
        tick = run && (st_q.cnt == lim - DIV_W'(1));
        st_d = st_q;
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: phase counter never passes the selected phase length
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> st_q.cnt < lim);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              abort,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              fin,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TOTAL = PRE_LEN + CMD_W;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] I_PRE   = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] I_DREND = IDX_W'(PRE_LEN + HDR_BITS);
    localparam logic [IDX_W-1:0] I_DATA  = IDX_W'(PRE_LEN + HDR_BITS + TA_BITS);
    localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(TOTAL - 1);

    typedef struct packed {
        logic              busy;
        logic              mdc;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [CMD_W-1:0]  sh;
        logic [DATA_W-1:0] rdat;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fin  = 1'b0;
        if (abort) begin
            st_d.busy = 1'b0;
            st_d.mdc  = 1'b0;
            st_d.idx  = '0;
        end else if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.mdc  = 1'b0;
                st_d.idx  = '0;
                st_d.sh   = cmd;
                st_d.rd   = cmd_is_read(cmd);
                st_d.rdat = '0;
            end
        end else if (tick) begin
            if (!st_q.mdc) begin
                // rising MDC: sample
                st_d.mdc = 1'b1;
                if (st_q.rd && st_q.idx >= I_DATA)
                    st_d.rdat = {st_q.rdat[DATA_W-2:0], mdio_i};
            end else begin
                // falling MDC: advance to next bit
                st_d.mdc = 1'b0;
                if (st_q.idx == I_LAST) begin
                    st_d.busy = 1'b0;
                    st_d.idx  = '0;
                    fin       = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                    if (st_q.idx >= I_PRE)
                        st_d.sh = {st_q.sh[CMD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign mdc     = st_q.mdc;
    assign mdio_o  = st_q.busy && ((st_q.idx < I_PRE) ? 1'b1 : st_q.sh[CMD_W-1]);
    assign mdio_oe = st_q.busy && (!st_q.rd || st_q.idx < I_DREND);
    assign rd_data = st_q.rdat;

    // R6: line is settled whenever MDC rises
    p_stable_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R5: quiet bus while idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.mdc && !mdio_oe);

    // R7: completion ends the transaction on the next edge
    p_fin_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !st_q.busy && !st_q.mdc);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_q,
    input  logic              spd_we,
    input  logic [DIV_W-1:0]  spd_wdata,
    output logic [DIV_W-1:0]  half_cyc,
    input  logic              evt_we,
    input  logic              evt_wbit,
    output logic              done,
    input  logic              srst_req,
    output logic              srst_busy,
    input  logic              busy,
    input  logic              fin,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output logic              abort
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [DIV_W-1:0] spd;
        logic             done;
        logic [RC_W-1:0]  rcnt;
    } reg_t;

    reg_t st_d, st_q;
    logic in_rst;

    always_comb begin
        in_rst = (st_q.rcnt != '0);
        start  = cmd_we && !busy && !in_rst;
        abort  = in_rst;
        st_d   = st_q;

        if (start) st_d.cmd = cmd_wdata;
        if (fin)
            st_d.cmd = cmd_is_read(st_q.cmd) ? {st_q.cmd[CMD_W-1:DATA_W], rd_data}
                                             : st_q.cmd;

        if (spd_we) st_d.spd = spd_wdata;

        // completion set wins over a simultaneous clear
        if (evt_we && evt_wbit) st_d.done = 1'b0;
        if (fin)                st_d.done = 1'b1;
        if (in_rst)             st_d.done = 1'b0;

        if (in_rst)        st_d.rcnt = st_q.rcnt - RC_W'(1);
        else if (srst_req) st_d.rcnt = RC_W'(RST_CYCLES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_q     = st_q.cmd;
    assign half_cyc  = st_q.spd;
    assign done      = st_q.done;
    assign srst_busy = in_rst;

    // R8: flag stays until explicitly cleared
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !(evt_we && evt_wbit) && !in_rst |=> st_q.done);

    // R9: command register frozen during a transaction
    p_cmd_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fin |=> $stable(st_q.cmd));

    // R10: soft reset leaves the shifter idle
    p_srst_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst |=> !busy);

    // R7: completion raises the flag
    p_done_after_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !in_rst |=> st_q.done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter int PRE_LEN    = 32,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    input  logic             spd_we,
    input  logic [DIV_W-1:0] spd_wdata,
    input  logic             evt_we,
    input  logic             evt_wbit,
    output logic             done,
    output logic             busy,
    input  logic             srst_req,
    output logic             srst_busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [DIV_W-1:0]  half_cyc;
    logic              start, abort, fin, tick;
    logic [DATA_W-1:0] rd_data;

    mdio_regs #(.DIV_W(DIV_W), .RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .cmd_q     (cmd_rdata),
        .spd_we    (spd_we),
        .spd_wdata (spd_wdata),
        .half_cyc  (half_cyc),
        .evt_we    (evt_we),
        .evt_wbit  (evt_wbit),
        .done      (done),
        .srst_req  (srst_req),
        .srst_busy (srst_busy),
        .busy      (busy),
        .fin       (fin),
        .rd_data   (rd_data),
        .start     (start),
        .abort     (abort)
    );

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_cyc (half_cyc),
        .tick     (tick)
    );

    mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd     (cmd_wdata),
        .abort   (abort),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .fin     (fin),
        .rd_data (rd_data)
    );
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        spd_we = 1'b0;
    logic [5:0]  spd_wdata = '0;
    logic        evt_we = 1'b0;
    logic        evt_wbit = 1'b0;
    logic        done, busy, srst_busy, mdc, mdio_o, mdio_oe, mdio_i;
    logic        srst_req = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .spd_we(spd_we), .spd_wdata(spd_wdata),
        .evt_we(evt_we), .evt_wbit(evt_wbit), .done(done), .busy(busy),
        .srst_req(srst_req), .srst_busy(srst_busy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // PHY model and line capture
    int          rise_cnt = 0;
    logic [63:0] cap_b = '0, cap_oe = '0;
    logic        phy_present = 1'b0;
    logic [15:0] phy_data = '0;
    logic        phy_en = 1'b0, phy_bit = 1'b1;
    assign mdio_i = phy_en ? phy_bit : 1'b1;   // pull-up

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_b[63-rise_cnt]  = mdio_o;
            cap_oe[63-rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (phy_present && rise_cnt >= 47 && rise_cnt <= 63) begin
            phy_en  = 1'b1;
            phy_bit = (rise_cnt == 47) ? 1'b0 : phy_data[63-rise_cnt];
        end else begin
            phy_en = 1'b0;
        end
    end

    typedef struct packed {
        logic       rd;
        logic [4:0] pa;
        logic [4:0] ra;
        logic [15:0] val;   // write data or PHY read data
        logic       phy;
        logic [5:0] f;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 5'd1,  5'd2,  16'h7A3C, 1'b1, 6'd2},
        '{1'b0, 5'd31, 5'd0,  16'h1200, 1'b0, 6'd1},
        '{1'b1, 5'd0,  5'd31, 16'h0000, 1'b1, 6'd3},
        '{1'b1, 5'd5,  5'd1,  16'hDEAD, 1'b0, 6'd2},
        '{1'b0, 5'd17, 5'd4,  16'hFFFF, 1'b0, 6'd3},
        '{1'b1, 5'd31, 5'd31, 16'h8001, 1'b1, 6'd1}
    };

    function automatic logic [31:0] mk_cmd(input logic rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] v);
        if (rd) return 32'h60020000 | (32'(pa) << 23) | (32'(ra) << 18);
        return 32'h50020000 | (32'(pa) << 23) | (32'(ra) << 18) | 32'(v);
    endfunction

    int busy_cnt, mdc_hi;

    task automatic set_speed(input logic [5:0] f);
        spd_we = 1'b1; spd_wdata = f;
        @(negedge clk);
        spd_we = 1'b0;
    endtask

    // issue a command, optionally inject a second write at busy count inj
    task automatic run_txn(input logic [31:0] cmd, input logic pres, input logic [15:0] pd,
                           input int inj, input logic [31:0] inj_cmd);
        int guard = 0;
        phy_present = pres; phy_data = pd; phy_en = 1'b0;
        rise_cnt = 0; cap_b = '0; cap_oe = '0;
        cmd_we = 1'b1; cmd_wdata = cmd;
        @(negedge clk);
        cmd_we = 1'b0;
        busy_cnt = 0; mdc_hi = 0;
        while (busy && guard < 20000) begin
            busy_cnt++;
            if (mdc) mdc_hi++;
            if (busy_cnt == inj) begin cmd_we = 1'b1; cmd_wdata = inj_cmd; end
            else cmd_we = 1'b0;
            guard++;
            @(negedge clk);
        end
        cmd_we = 1'b0;
        phy_present = 1'b0;
    endtask

    task automatic clear_done();
        evt_we = 1'b1; evt_wbit = 1'b1;
        @(negedge clk);
        evt_we = 1'b0; evt_wbit = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 64'(n_chk), 64'(0));
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] c, rep;
        logic [63:0] eoe;
        int eff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R5 idle bus, R7/R8 quiet flags, R10 no reset in progress)
        chk(!busy && !done, "R7 R8 reset flags", {62'b0, busy, done}, 64'(0));
        chk(!mdc && !mdio_oe, "R5 reset bus idle", {62'b0, mdc, mdio_oe}, 64'(0));
        chk(!srst_busy && cmd_rdata == 32'h0, "R10 reset regs", {31'b0, srst_busy, cmd_rdata}, 64'(0));

        // table-driven transactions
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            c = mk_cmd(v.rd, v.pa, v.ra, v.val);
            set_speed(v.f);
            run_txn(c, v.phy, v.val, -1, 32'h0);
            rep = v.rd ? {c[31:16], v.phy ? v.val : 16'hFFFF} : c;
            eoe = v.rd ? (~64'h0 << 18) : ~64'h0;
            chk(cap_oe == eoe, v.rd ? "R2 drive mask read" : "R3 drive mask write", cap_oe, eoe);
            chk((cap_b & eoe) == ({32'hFFFFFFFF, c} & eoe), "R1 serial frame",
                cap_b & eoe, {32'hFFFFFFFF, c} & eoe);
            if (v.rd && !v.phy) chk(cmd_rdata == rep, "R4 no PHY reply", 64'(cmd_rdata), 64'(rep));
            else if (v.rd)      chk(cmd_rdata == rep, "R2 read reply", 64'(cmd_rdata), 64'(rep));
            else                chk(cmd_rdata == rep, "R3 write reply", 64'(cmd_rdata), 64'(rep));
            chk(busy_cnt == 128 * int'(v.f), "R7 busy length", 64'(busy_cnt), 64'(128 * int'(v.f)));
            chk(mdc_hi == 64 * int'(v.f), "R5 MDC high time", 64'(mdc_hi), 64'(64 * int'(v.f)));
            chk(rise_cnt == 64, "R6 MDC rise count", 64'(rise_cnt), 64'(64));
            chk(done, "R8 done set", 64'(done), 64'(1));
            clear_done();
            chk(!done, "R8 done cleared by 1", 64'(done), 64'(0));
        end

        // R8: writing 0 leaves the flag set
        set_speed(6'd1);
        run_txn(mk_cmd(1'b0, 5'd3, 5'd9, 16'hA5A5), 1'b0, 16'h0, -1, 32'h0);
        evt_we = 1'b1; evt_wbit = 1'b0;
        @(negedge clk);
        evt_we = 1'b0;
        @(negedge clk);
        chk(done, "R8 write 0 keeps done", 64'(done), 64'(1));
        clear_done();

        // R9: second command during busy is ignored
        set_speed(6'd2);
        c = mk_cmd(1'b1, 5'd9, 5'd3, 16'h0);
        run_txn(c, 1'b1, 16'h1234, 40, mk_cmd(1'b0, 5'd2, 5'd2, 16'hBEEF));
        chk(cmd_rdata == {c[31:16], 16'h1234}, "R9 reply unaffected",
            64'(cmd_rdata), 64'({c[31:16], 16'h1234}));
        chk(busy_cnt == 256, "R9 no restart", 64'(busy_cnt), 64'(256));
        repeat (4) @(negedge clk);
        chk(!busy, "R9 stays idle", 64'(busy), 64'(0));
        clear_done();

        // R10: soft reset aborts a transaction and clears done
        run_txn(mk_cmd(1'b0, 5'd1, 5'd1, 16'h1111), 1'b0, 16'h0, -1, 32'h0);
        chk(done, "R10 done before reset", 64'(done), 64'(1));
        c = mk_cmd(1'b0, 5'd4, 5'd6, 16'h5A5A);
        cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (50) @(negedge clk);
        srst_req = 1'b1;
        @(negedge clk);
        srst_req = 1'b0;
        eff = 0;
        for (int k = 0; k < 30; k++) begin
            if (srst_busy) eff++;
            if (k == 2) begin cmd_we = 1'b1; cmd_wdata = 32'h6FFC0000; end
            else cmd_we = 1'b0;
            @(negedge clk);
        end
        chk(eff == 8, "R10 reset bit duration", 64'(eff), 64'(8));
        chk(!busy && !mdc && !mdio_oe, "R10 aborted bus idle", {61'b0, busy, mdc, mdio_oe}, 64'(0));
        chk(!done, "R10 done cleared", 64'(done), 64'(0));
        chk(cmd_rdata == c, "R10 command ignored in reset", 64'(cmd_rdata), 64'(c));

        // R5: F=0 behaves as 1; host value 100 gives F=50
        set_speed(6'd0);
        run_txn(mk_cmd(1'b0, 5'd0, 5'd0, 16'h0001), 1'b0, 16'h0, -1, 32'h0);
        chk(busy_cnt == 128, "R5 F=0 as 1", 64'(busy_cnt), 64'(128));
        clear_done();
        spd_we = 1'b1; spd_wdata = 7'(100) >> 1;
        @(negedge clk);
        spd_we = 1'b0;
        run_txn(mk_cmd(1'b1, 5'd2, 5'd1, 16'h0), 1'b1, 16'hC3C3, -1, 32'h0);
        chk(busy_cnt == 6400, "R5 F=50 busy", 64'(busy_cnt), 64'(6400));
        chk(mdc_hi == 3200, "R5 F=50 MDC high", 64'(mdc_hi), 64'(3200));
        chk(cmd_rdata[15:0] == 16'hC3C3, "R2 slow read data", 64'(cmd_rdata[15:0]), 64'(16'hC3C3));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule